// File: doc/BRIEF.md
# Double Noise Rejection Delay Window

This block holds a single-channel detector hit for a fixed latency so that a downstream trigger decision can be made before the hit is stored. Each hit produces a short output pulse that starts a programmed number of clock cycles after the hit. The timing comes from digital counters, so the delay and width do not drift with component values. The input is a single-bit hit that is already synchronized to the clock. The output is the delayed and shaped single-bit pulse. Trigger coincidence and storage are handled downstream.

Two delay cells run side by side, and their pulses are ORed to form the output. The first cell cannot be retriggered: it records the first hit seen while it is idle and ignores every later hit until its delay-plus-width cycle is over. The second cell can be retriggered: every hit restarts it, so it always reports the most recent hit. Together they report both the earliest and the latest hit of a burst. A hit that arrives while the first cell is busy is therefore not lost, and the dead time shrinks to about one pulse width. With a 20 MHz clock, the default of 64 cycles gives a 3.2 µs delay and the default of 4 cycles gives a 200 ns pulse.

The hit input and the pulse output are plain timing signals and carry no handshake. A pulse cannot be held back, so there is no back-pressure path, and the pulse position is fixed by the hit cycle alone.

Top module: `dnr_window`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is low and both cells are cleared. After reset is released, no pulse appears until a hit occurs.
- R2: A hit is counted at the clock edge where `hit_in` is 1 and was 0 at the previous edge. An isolated hit at edge k drives `pulse_out` high for exactly WIDTH cycles, from edge k+DELAY until edge k+DELAY+WIDTH. The two cells never make this pulse longer or make it appear twice.
- R3: A `hit_in` level held high for many cycles counts as one hit, at its first edge.
- R4: The first cell accepts a hit only when it is idle, and then ignores later hits. A burst of hits therefore always yields a pulse placed DELAY cycles after the burst's first hit.
- R5: The second cell restarts on every hit. A burst yields a pulse placed DELAY cycles after its last hit, and hits strictly between the first and the last produce no pulse.
- R6: `pulse_out` is the OR of both cells' pulses. Pulses that overlap or touch merge into one longer pulse.
- R7: The first cell re-arms on the edge DELAY+WIDTH cycles after its accepted hit. A hit at exactly that edge is accepted by the first cell.
- R8: Asserting reset while pulses are pending cancels them, and no pulse is produced for hits seen before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; 20 MHz gives the default 3.2 µs / 200 ns timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 1 | Synchronized hit level; a rising edge is one hit |
| pulse_out | output | 1 | Delayed, shaped hit pulse |

## Verification
Each pattern is chosen so that a wrong design produces a different output from the model.

- A lone one-cycle hit shows the pulse position and width, and shows that the two cells do not widen or double the pulse.
- A long high level separates edge detection from level sensing.
- A pair of hits and a three-hit burst separate the first-hit cell from the last-hit cell, and show that a middle hit is dropped.
- Two hits two cycles apart show the OR merge.
- A hit landing exactly on the first cell's re-arm edge pins down the end of that cell's busy period by one cycle.
- A reset issued while a pulse is pending shows that pending pulses are cancelled.

// File: rtl/dnr_pkg.sv
package dnr_pkg;
  // Selects how a delay cell reacts to a hit that arrives while it is busy.
  typedef enum logic {
    MODE_FIRST = 1'b0,  // busy cell ignores new hits
    MODE_LAST  = 1'b1   // every hit restarts the cell
  } cell_mode_e;
endpackage

// File: rtl/dnr_edge_detect.sv
module dnr_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/dnr_delay_cell.sv
module dnr_delay_cell #(
  parameter int DELAY = 64,
  parameter int WIDTH = 4,
  parameter dnr_pkg::cell_mode_e MODE = dnr_pkg::MODE_FIRST
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic pulse_o
);
  localparam int SPAN = DELAY + WIDTH;
  localparam int CW   = $clog2(SPAN + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          last;
  logic          start;

  // last: the final cycle of the pulse window
  assign last = active_q && (cnt_q == CW'(SPAN));

  generate
    if (MODE == dnr_pkg::MODE_LAST) begin : g_retrig
      assign start = hit_i;

      a_r5_restart_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (active_q && cnt_q == CW'(1)));
    end else begin : g_single
      assign start = hit_i && (!active_q || last);

      a_r4_busy_ignores_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !last) |=> (active_q && cnt_q == $past(cnt_q) + CW'(1)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(1);
    end else if (last) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end

  // cnt_q runs 1..SPAN; the pulse covers its last WIDTH values
  assign pulse_o = active_q && (cnt_q > CW'(DELAY));

  a_r2_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !hit_i && !last) |=> active_q);
endmodule

// File: rtl/dnr_window.sv
module dnr_window #(
  parameter int DELAY = 64,
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_in,
  output logic pulse_out
);
  localparam int NCELL = 2;

  logic             hit_edge;
  logic [NCELL-1:0] cell_pulse;

  dnr_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (hit_in),
    .rise_o  (hit_edge)
  );

  generate
    for (genvar g = 0; g < NCELL; g++) begin : g_cell
      localparam dnr_pkg::cell_mode_e CMODE =
        (g == 0) ? dnr_pkg::MODE_FIRST : dnr_pkg::MODE_LAST;
      dnr_delay_cell #(
        .DELAY (DELAY),
        .WIDTH (WIDTH),
        .MODE  (CMODE)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit_edge),
        .pulse_o (cell_pulse[g])
      );
    end
  endgenerate

  assign pulse_out = |cell_pulse;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !pulse_out);
endmodule

// File: tb/dnr_window_test.sv
module dnr_window_test;
  localparam int D = 64;
  localparam int W = 4;
  localparam int NONE = -100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_in = 1'b0;
  logic pulse_out;

  int tests = 0;
  int fails = 0;
  int m = 0;            // edge index
  int h1 = NONE;        // hit held by the first-hit cell
  int h2 = NONE;        // most recent hit
  bit prev = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  dnr_window #(.DELAY(D), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .pulse_out(pulse_out)
  );

  always #10 clk = ~clk;

  function automatic bit in_win(int d);
    return (d >= D) && (d <= D + W - 1);
  endfunction

  task automatic step(input bit h, input bit r);
    hit_in = h;
    rst_n  = !r;
    @(posedge clk);
    m++;
    if (r) begin
      h1 = NONE; h2 = NONE; prev = 1'b0;
    end else begin
      if (h && !prev) begin
        if (h1 == NONE || (m - h1) >= D + W) h1 = m;
        h2 = m;
      end
      prev = h;
    end
    @(negedge clk);
    begin
      bit exp;
      exp = in_win(m - h1) || in_win(m - h2);
      tests++;
      if (pulse_out !== exp) begin
        fails++;
        $display("FAIL %s edge %0d: pulse_out=%b expected=%b", tag, m, pulse_out, exp);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state and quiet after release
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    idle(80);
    // R2: single isolated hit
    tag = "R2";
    step(1'b1, 1'b0);
    idle(80);
    // R3: long level counts once
    tag = "R3";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    idle(90);
    // R4: two hits, first one still reported
    tag = "R4";
    step(1'b1, 1'b0); idle(29); step(1'b1, 1'b0);
    idle(90);
    // R5: three-hit burst, middle dropped
    tag = "R5";
    step(1'b1, 1'b0); idle(9); step(1'b1, 1'b0); idle(9); step(1'b1, 1'b0);
    idle(90);
    // R6: overlapping pulses merge
    tag = "R6";
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
    idle(90);
    // R7: hit on the exact re-arm edge
    tag = "R7";
    step(1'b1, 1'b0); idle(D + W - 1); step(1'b1, 1'b0);
    step(1'b0, 1'b0); step(1'b1, 1'b0);
    idle(90);
    // R8: reset cancels pending pulses
    tag = "R8";
    step(1'b1, 1'b0); idle(30);
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    idle(90);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule